// File: doc/BRIEF.md
# Two-Stage Segmented Converter Code Register

This block is the digital front end of a 12-bit converter. A host writes the converter word in pieces of four bits each. Each piece goes into its own first-stage holding register, and the block then moves the assembled word into a second-stage register in one step. Only the second-stage register drives the converter code. The host can therefore prepare the next word over several bus cycles while the output stays steady.

The block connects to a 4-, 8- or 16-bit host bus. Three segment enables, qualified by an active-low select, choose which pieces accept data. A separate load strobe opens the second stage. Every control acts as a level-sensitive latch, modelled on a system clock. While a gate is open, its register takes the input on every clock. When the gate closes, the register keeps the last value it took.

A built-in checker counts clock cycles against three rules:
- data setup before a segment closes,
- the minimum width of the select and segment-enable overlap,
- the minimum width of the load strobe.

Any breach of these rules raises a sticky error flag.

Top module: `dbl_buf_dac_if`

## Requirements
- R1: While reset is asserted, and after it is released, all holding registers and `code` are zero and `timing_err` is 0.
- R2: While `sel_n`=0 and `seg_en[i]`=1, segment i takes its slice of `din` at each clock edge. `seg_en[2]` maps to bits 11:8, `seg_en[1]` to bits 7:4 and `seg_en[0]` to bits 3:0.
- R3: With `sel_n`=1, no segment changes, whatever `seg_en` and `din` are. A later transfer makes this visible at `code`.
- R4: While `load`=0, `code` holds its value even when the holding registers change.
- R5: While `load`=1, `code` follows the holding registers with no extra delay. A segment written at a clock edge shows on `code` after that same edge.
- R6: With the default parameter setting (`XFER_NEEDS_SEL`=0), a transfer happens whatever the state of `sel_n`.
- R7: When a segment gate closes, the segment keeps the data it held at the last edge the gate was open. `din` values that follow are ignored.
- R8: If a segment gate closes after `din` has been steady for fewer than `SETUP_CYC` cycles (the capture cycle counts), `timing_err` is 1 after the edge that sees the close.
- R9: If a segment gate (select low and enable high) stays open for fewer than `OVERLAP_CYC` cycles, `timing_err` is set at its close. The same holds if `load` stays high for fewer than `WIDTH_CYC` cycles, with the flag set at its fall.
- R10: Once set, `timing_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 12 | Data bus to the holding registers |
| sel_n | input | 1 | Active-low select that qualifies the segment enables |
| seg_en | input | 3 | Segment enables: [2] high, [1] middle, [0] low nibble |
| load | input | 1 | Transfer strobe, level sensitive, 1 = second stage follows |
| code | output | 12 | Converter code held in the second stage |
| timing_err | output | 1 | Sticky flag for a setup, overlap or strobe-width breach |

## Verification
Any wrong value in a holding register reaches `code` only through a transfer. With `load` held high it shows one edge after the bad write; otherwise it stays hidden until the next load pulse. The bench therefore follows every write sequence with a transfer and compares `code` on every cycle. A wrong transfer path shows on `code` one edge after `load` changes. A lost or spurious timing breach shows on `timing_err` one edge after the offending strobe falls, and stays there because the flag is sticky.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic [1:0] {
    SEG_LO  = 2'd0,
    SEG_MID = 2'd1,
    SEG_HI  = 2'd2
  } seg_idx_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dacif_seg_reg.sv
module dacif_seg_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic [W-1:0] q_r;

  always_comb begin
    q_next = open ? d : q_r;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else         q_r <= q_next;
  end

  assign q = q_r;

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !open |=> $stable(q)); // R3
  AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    open |=> q == $past(d)); // R2
endmodule

// File: rtl/dacif_xfer_reg.sv
module dacif_xfer_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         xfer,
  input  logic [W-1:0] stage1_next,
  output logic [W-1:0] code
);
  logic [W-1:0] code_r, code_d;

  always_comb begin
    code_d = xfer ? stage1_next : code_r;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) code_r <= '0;
    else         code_r <= code_d;
  end

  assign code = code_r;

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !xfer |=> $stable(code)); // R4
endmodule

// File: rtl/dacif_timing_chk.sv
module dacif_timing_chk #(
  parameter int NUM_SEG     = 3,
  parameter int DATA_W      = 12,
  parameter int SETUP_CYC   = 3,
  parameter int WIDTH_CYC   = 3,
  parameter int OVERLAP_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  din,
  input  logic [NUM_SEG-1:0] gate,
  input  logic               load_eff,
  output logic               err
);
  import dacif_pkg::*;

  localparam int NSTRB = NUM_SEG + 1;
  localparam int MAXC  = max3(SETUP_CYC, WIDTH_CYC, OVERLAP_CYC);
  localparam int CNT_W = (MAXC < 1) ? 1 : $clog2(MAXC + 1);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX   = cnt_t'(MAXC);
  localparam cnt_t SETUP_LIM = cnt_t'(SETUP_CYC);

  logic [NSTRB-1:0]  strb, strb_q, viol;
  logic [DATA_W-1:0] din_q;
  cnt_t              stab_q, stab_d;
  logic              err_q, err_d;

  assign strb = {load_eff, gate};

  always_comb begin
    if (din != din_q)         stab_d = cnt_t'(1);
    else if (stab_q == CNT_MAX) stab_d = stab_q;
    else                      stab_d = stab_q + cnt_t'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q  <= '0;
      stab_q <= '0;
      strb_q <= '0;
    end else begin
      din_q  <= din;
      stab_q <= stab_d;
      strb_q <= strb;
    end
  end

  for (genvar g = 0; g < NSTRB; g++) begin : g_strb
    localparam bit   IS_SEG = (g < NUM_SEG);
    localparam cnt_t LIM    = IS_SEG ? cnt_t'(OVERLAP_CYC) : cnt_t'(WIDTH_CYC);
    cnt_t wid_q, wid_d;
    logic fall;

    assign fall = strb_q[g] & ~strb[g];

    always_comb begin
      if (!strb[g])             wid_d = '0;
      else if (wid_q == CNT_MAX) wid_d = wid_q;
      else                      wid_d = wid_q + cnt_t'(1);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) wid_q <= '0;
      else         wid_q <= wid_d;
    end

    assign viol[g] = fall & ((wid_q < LIM) | (IS_SEG & (stab_q < SETUP_LIM)));

    AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
      (fall && wid_q < LIM) |=> err); // R9
    if (IS_SEG) begin : g_setup
      AST_SETUP_MISS: assert property (@(posedge clk) disable iff (!rst_ni)
        (fall && stab_q < SETUP_LIM) |=> err); // R8
    end
  end

  always_comb begin
    err_d = err_q | (|viol);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    err |=> err); // R10
endmodule

// File: rtl/dbl_buf_dac_if.sv
module dbl_buf_dac_if #(
  parameter int SEG_W          = 4,
  parameter int NUM_SEG        = 3,
  parameter int SETUP_CYC      = 3,
  parameter int WIDTH_CYC      = 3,
  parameter int OVERLAP_CYC    = 3,
  parameter bit XFER_NEEDS_SEL = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEG_W*NUM_SEG-1:0]   din,
  input  logic                       sel_n,
  input  logic [NUM_SEG-1:0]         seg_en,
  input  logic                       load,
  output logic [SEG_W*NUM_SEG-1:0]   code,
  output logic                       timing_err
);
  localparam int DATA_W = SEG_W * NUM_SEG;

  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  logic [NUM_SEG-1:0] gate;
  logic               load_eff;
  logic [DATA_W-1:0]  stage1_q, stage1_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign gate = {NUM_SEG{~sel_n}} & seg_en;

  if (XFER_NEEDS_SEL) begin : g_xfer_sel
    assign load_eff = load & ~sel_n;
  end else begin : g_xfer_free
    assign load_eff = load;
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    dacif_seg_reg #(.W(SEG_W)) u_seg (
      .clk    (clk),
      .rst_ni (rst_ni),
      .open   (gate[g]),
      .d      (din[g*SEG_W +: SEG_W]),
      .q      (stage1_q[g*SEG_W +: SEG_W]),
      .q_next (stage1_d[g*SEG_W +: SEG_W])
    );
  end

  dacif_xfer_reg #(.W(DATA_W)) u_xfer (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .xfer        (load_eff),
    .stage1_next (stage1_d),
    .code        (code)
  );

  dacif_timing_chk #(
    .NUM_SEG     (NUM_SEG),
    .DATA_W      (DATA_W),
    .SETUP_CYC   (SETUP_CYC),
    .WIDTH_CYC   (WIDTH_CYC),
    .OVERLAP_CYC (OVERLAP_CYC)
  ) u_chk (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .din      (din),
    .gate     (gate),
    .load_eff (load_eff),
    .err      (timing_err)
  );

  AST_CODE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    load_eff |=> code == stage1_q); // R5
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_ni |-> (code == '0 && stage1_q == '0 && !timing_err)); // R1
endmodule

// File: tb/dbl_buf_dac_if_tb.sv
module dbl_buf_dac_if_tb;
  logic        clk;
  logic        rst_n;
  logic [11:0] din;
  logic        sel_n;
  logic [2:0]  seg_en;
  logic        load;
  logic [11:0] code;
  logic        timing_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [11:0] m_s1, m_code;
  logic        m_err;

  logic [11:0] q_code[$];
  logic        q_err[$];
  string       q_tag[$];

  dbl_buf_dac_if u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .sel_n(sel_n), .seg_en(seg_en),
    .load(load), .code(code), .timing_err(timing_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: compares each expected item 1 ns after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (q_code.size() > 0) begin
      logic [11:0] ec;
      logic        ee;
      string       t;
      ec = q_code.pop_front();
      ee = q_err.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (code !== ec || timing_err !== ee) begin
        errors++;
        $display("FAIL %s: code=%h err=%b expected code=%h err=%b", t, code, timing_err, ec, ee);
      end
    end
  end

  task automatic step(input logic [11:0] d, input logic s_n, input logic [2:0] e,
                      input logic ld, input logic set_err, input string tag);
    @(negedge clk);
    din = d; sel_n = s_n; seg_en = e; load = ld;
    for (int i = 0; i < 3; i++)
      if (!s_n && e[i]) m_s1[i*4 +: 4] = d[i*4 +: 4];
    if (ld) m_code = m_s1;
    if (set_err) m_err = 1'b1;
    q_code.push_back(m_code);
    q_err.push_back(m_err);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] e, input logic [11:0] d, input logic ld, input string tag);
    for (int k = 0; k < 3; k++) step(d, 1'b0, e, ld, 1'b0, tag);
    step(d, 1'b0, 3'b000, ld, 1'b0, tag);
  endtask

  task automatic xfer(input logic s_n, input string tag);
    for (int k = 0; k < 3; k++) step(din, s_n, 3'b000, 1'b1, 1'b0, tag);
    step(din, s_n, 3'b000, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; din = '0; sel_n = 1'b1; seg_en = '0; load = 1'b0;
    m_s1 = '0; m_code = '0; m_err = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (code !== 12'h000 || timing_err !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset code=%h err=%b expected code=000 err=0", code, timing_err);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; din = '0; sel_n = 1'b1; seg_en = '0; load = 1'b0;
    m_s1 = '0; m_code = '0; m_err = 1'b0;
    do_reset();
    step(12'h000, 1'b1, 3'b000, 1'b0, 1'b0, "R1 after release");

    // R2: each enable maps to its own nibble
    wr(3'b100, 12'hABC, 1'b0, "R2 high write");
    xfer(1'b1, "R2 high transfer");
    wr(3'b010, 12'h5D1, 1'b0, "R2 mid write");
    wr(3'b001, 12'h00E, 1'b0, "R2 low write");
    xfer(1'b1, "R2 full word");

    // R3: select high blocks every segment
    for (int k = 0; k < 4; k++) step(12'hFFF, 1'b1, 3'b111, 1'b0, 1'b0, "R3 deselected");
    xfer(1'b1, "R3 unchanged after transfer");

    // R4: stage one changes, code holds
    wr(3'b001, 12'h777, 1'b0, "R4 hold while load low");
    xfer(1'b1, "R4 then transfer");

    // R5: load held high, code flows through
    step(din, 1'b1, 3'b000, 1'b1, 1'b0, "R5 load open");
    wr(3'b010, 12'h090, 1'b1, "R5 flow-through");
    step(din, 1'b1, 3'b000, 1'b0, 1'b0, "R5 load close");

    // R6: transfer with select high
    wr(3'b100, 12'h300, 1'b0, "R6 prepare");
    xfer(1'b1, "R6 transfer without select");

    // R7: data after the gate closes is ignored
    for (int k = 0; k < 3; k++) step(12'h0C0, 1'b0, 3'b010, 1'b0, 1'b0, "R7 open");
    step(12'hFFF, 1'b0, 3'b000, 1'b0, 1'b0, "R7 close with new data");
    step(12'h123, 1'b1, 3'b000, 1'b0, 1'b0, "R7 later data");
    xfer(1'b1, "R7 captured value");

    // R8: setup breach, then R10 stickiness
    step(12'h111, 1'b0, 3'b001, 1'b0, 1'b0, "R8 open");
    step(12'h222, 1'b0, 3'b001, 1'b0, 1'b0, "R8 data moving");
    step(12'h333, 1'b0, 3'b001, 1'b0, 1'b0, "R8 data moving");
    step(12'h333, 1'b0, 3'b000, 1'b0, 1'b1, "R8 close too soon after change");
    for (int k = 0; k < 6; k++) step(12'h000, 1'b1, 3'b000, 1'b0, 1'b0, "R10 flag stays set");
    xfer(1'b1, "R10 flag stays set across transfer");

    // R9: short overlap
    do_reset();
    step(12'h000, 1'b1, 3'b000, 1'b0, 1'b0, "R1 after second reset");
    for (int k = 0; k < 3; k++) step(12'h654, 1'b1, 3'b100, 1'b0, 1'b0, "R9 data settle");
    step(12'h654, 1'b0, 3'b100, 1'b0, 1'b0, "R9 one-cycle overlap");
    step(12'h654, 1'b1, 3'b100, 1'b0, 1'b1, "R9 overlap too short");

    // R9: short load strobe
    do_reset();
    step(12'h000, 1'b1, 3'b000, 1'b1, 1'b0, "R9 one-cycle load");
    step(12'h000, 1'b1, 3'b000, 1'b0, 1'b1, "R9 load too short");
    step(12'h000, 1'b1, 3'b000, 1'b0, 1'b0, "R10 flag stays set");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule